// File: doc/BRIEF.md
# Tone Burst Transmit Sequencer

This block decides when a tone-pair generator is switched on after the host writes a code to the transmit data register. It also decides which tone groups are switched on. In timed mode a write starts a tone burst that lasts a fixed number of timebase ticks. A silent pause of the same number of ticks follows, and a one-cycle ready pulse then tells the host that the next code may be written. In host-timed mode the tone follows a level input from the host for as long as the host holds it, and no ready pulse is produced.

A call-progress option doubles the tick count of both the burst and the pause. The count is captured when the write is accepted. Two group-enable outputs, one for the low (row) group and one for the high (column) group, select dual-tone output or a single group. The frequency synthesiser downstream uses these two enables.

Top module: `tone_burst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `low_en_o`, `high_en_o` and `ready_o` are 0.
- R2: With `burst_n_i`=0, a write (`wr_i`=1 for one clock) from idle starts a burst in the next cycle. The tone enables stay on until exactly L ticks (`tick_i` high at a rising clock edge) have been consumed. L is BASE_TICKS, or 2*BASE_TICKS in call-progress mode.
- R3: A pause of exactly L ticks follows the burst. Both tone enables are 0 throughout the pause.
- R4: `ready_o` is 1 for exactly one cycle, the cycle after the clock edge that consumes the last pause tick. At no other time is it 1 in timed mode.
- R5: L is 2*BASE_TICKS when `cp_mode_i`=1 at the accepted write and BASE_TICKS otherwise. A change of `cp_mode_i` during a burst or pause has no effect on that sequence.
- R6: With `single_i`=0 (dual tone), `low_en_o` and `high_en_o` are both 1 whenever the tone is active.
- R7: With `single_i`=1, only `low_en_o` is 1 when `col_i`=0 (row group), and only `high_en_o` is 1 when `col_i`=1 (column group), while the tone is active.
- R8: With `burst_n_i`=1, the tone is active exactly while `tone_on_i`=1, with the group selection of R6/R7 applied combinationally. Writes start nothing, and `ready_o` stays 0.
- R9: A write during a burst or a pause is ignored. The burst and pause lengths and the timing of the ready pulse are unchanged.
- R10: A write in the cycle in which `ready_o` is 1 is accepted and starts a new burst in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one clock wide |
| wr_i | input | 1 | Transmit register write strobe |
| burst_n_i | input | 1 | 0 = timed burst mode, 1 = host-timed mode |
| cp_mode_i | input | 1 | 1 = double the burst and pause length |
| single_i | input | 1 | 0 = dual tone, 1 = single group |
| col_i | input | 1 | Single group choice: 0 = row (low), 1 = column (high) |
| tone_on_i | input | 1 | Host tone enable in host-timed mode |
| low_en_o | output | 1 | Low (row) group enable |
| high_en_o | output | 1 | High (column) group enable |
| ready_o | output | 1 | One-cycle pulse: transmitter ready for new data |

## Verification
Two events can fall in the same clock cycle: the end of a sequence, and a new write from the host. The bench places a write on the edge that consumes the last burst tick, on the edge that consumes the last pause tick, and in the ready cycle itself, each time with the call-progress input flipped. It then counts the ticks seen in each phase. The first two writes must leave both phase lengths at L. The write in the ready cycle must start a fresh burst of full length with no extra ready pulse.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_PAUSE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tbs_timer.sv
module tbs_timer #(
  parameter int unsigned BASE_TICKS = 51,
  parameter int unsigned CNT_W      = $clog2(2 * BASE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reload_i,
  input  logic run_i,
  input  logic cp_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BASE_TICKS);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(2 * BASE_TICKS);

  logic [CNT_W-1:0] len_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LEN_SHORT;
      cnt_q <= '0;
    end else if (start_i) begin
      len_q <= cp_i ? LEN_LONG : LEN_SHORT;
      cnt_q <= cp_i ? LEN_LONG : LEN_SHORT;
    end else if (reload_i) begin
      cnt_q <= len_q;  // pause reuses the latched burst length
    end else if (run_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && tick_i && (cnt_q == CNT_W'(1));

  // R5
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == LEN_SHORT) || (len_q == LEN_LONG));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_q);
  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(len_q));
endmodule

// File: rtl/tbs_fsm.sv
module tbs_fsm
  import tbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       burst_n_i,
  input  logic       expire_i,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       reload_o,
  output logic       run_o,
  output logic       ready_o
);
  seq_state_e state_q, state_d;
  logic       ready_q;

  assign start_o  = (state_q == ST_IDLE) && !burst_n_i && wr_i;
  assign reload_o = (state_q == ST_BURST) && expire_i;
  assign run_o    = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    if (burst_n_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_o)  state_d = ST_BURST;
        ST_BURST: if (expire_i) state_d = ST_PAUSE;
        ST_PAUSE: if (expire_i) state_d = ST_IDLE;
        default:                state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= !burst_n_i && (state_q == ST_PAUSE) && expire_i;
    end
  end

  assign state_o = state_q;
  assign ready_o = ready_q;

  // R4
  ready_after_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> ($past(state_q) == ST_PAUSE));
  // R9
  busy_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST && wr_i && !expire_i && !burst_n_i) |=> (state_q == ST_BURST));
  // R4
  ready_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
endmodule

// File: rtl/tbs_group_sel.sv
module tbs_group_sel (
  input  logic active_i,
  input  logic single_i,
  input  logic col_i,
  output logic low_o,
  output logic high_o
);
  assign low_o  = active_i && !(single_i && col_i);
  assign high_o = active_i && !(single_i && !col_i);

  // R7
  always_comb begin
    single_excl_chk: assert (!(single_i && low_o && high_o));
  end
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq
  import tbs_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 51
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_i,
  input  logic burst_n_i,
  input  logic cp_mode_i,
  input  logic single_i,
  input  logic col_i,
  input  logic tone_on_i,
  output logic low_en_o,
  output logic high_en_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(2 * BASE_TICKS + 1);

  seq_state_e state;
  logic       start, reload, run, expire, active;

  tbs_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .burst_n_i(burst_n_i),
    .expire_i (expire),
    .state_o  (state),
    .start_o  (start),
    .reload_o (reload),
    .run_o    (run),
    .ready_o  (ready_o)
  );

  tbs_timer #(
    .BASE_TICKS(BASE_TICKS),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .reload_i(reload),
    .run_i   (run),
    .cp_i    (cp_mode_i),
    .tick_i  (tick_i),
    .expire_o(expire)
  );

  assign active = burst_n_i ? tone_on_i : (state == ST_BURST);

  tbs_group_sel u_grp (
    .active_i(active),
    .single_i(single_i),
    .col_i   (col_i),
    .low_o   (low_en_o),
    .high_o  (high_en_o)
  );

  // R3
  pause_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PAUSE && !burst_n_i) |-> !(low_en_o || high_en_o));
  // R8
  no_ready_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(burst_n_i) |-> !ready_o);
endmodule

// File: tb/tone_burst_seq_test.sv
`timescale 1ns/1ps
module tone_burst_seq_test;
  localparam int unsigned B = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, wr_i = 1'b0, burst_n_i = 1'b0, cp_mode_i = 1'b0;
  logic single_i = 1'b0, col_i = 1'b0, tone_on_i = 1'b0;
  logic low_en_o, high_en_o, ready_o;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  tone_burst_seq #(.BASE_TICKS(B)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .burst_n_i(burst_n_i), .cp_mode_i(cp_mode_i), .single_i(single_i),
    .col_i(col_i), .tone_on_i(tone_on_i), .low_en_o(low_en_o),
    .high_en_o(high_en_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One timed sequence; returns at the negedge where ready_o is seen high.
  task automatic measure(input bit cp, input bit sg, input bit cl, input int per,
                         input bit inj, input bit do_wr);
    int bt = 0, pt = 0, phase = 0, grp_err = 0, pause_err = 0, n = 0;
    int len = cp ? 2 * B : B;
    bit lo, hi, rd, seen = 0;
    bit exp_lo = !(sg && cl);
    bit exp_hi = !(sg && !cl);
    single_i = sg; col_i = cl;
    if (do_wr) begin wr_i = 1'b1; cp_mode_i = cp; end
    while (n < 400) begin
      @(negedge clk_i);
      n++; cyc++;
      lo = low_en_o; hi = high_en_o; rd = ready_o;
      wr_i = 1'b0;
      cp_mode_i = !cp;  // must not alter the running sequence (R5)
      if (rd) begin seen = 1; break; end
      if (phase == 0 && (lo || hi)) phase = 1;
      else if (phase == 1 && !(lo || hi)) phase = 2;
      if (phase == 1 && (lo != exp_lo || hi != exp_hi)) grp_err++;
      if (phase == 2 && (lo || hi)) pause_err++;
      tick_i = ((cyc % per) == 0);
      if (inj && tick_i && phase == 1 && bt == len - 1) wr_i = 1'b1;  // R9 write on last burst tick
      if (inj && tick_i && phase == 2 && pt == len - 1) wr_i = 1'b1;  // R9 write on last pause tick
      if (inj && phase == 1 && bt == 1) wr_i = 1'b1;
      if (phase == 1 && tick_i) bt++;
      if (phase == 2 && tick_i) pt++;
    end
    chk(seen, "R4 ready pulse seen", seen, 1);
    chk(bt == len, cp ? "R5 burst ticks (call progress)" : "R2 burst ticks", bt, len);
    chk(pt == len, inj ? "R9 pause ticks with ignored writes" : "R3 pause ticks", pt, len);
    chk(grp_err == 0, sg ? "R7 single group enables" : "R6 dual group enables", grp_err, 0);
    chk(pause_err == 0, "R3 pause silent", pause_err, 0);
    tick_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!low_en_o && !high_en_o && !ready_o, "R1 outputs in reset",
        {low_en_o, high_en_o, ready_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!low_en_o && !high_en_o && !ready_o, "R1 outputs after reset",
        {low_en_o, high_en_o, ready_o}, 0);

    for (int cp = 0; cp < 2; cp++)
      for (int cfg = 0; cfg < 3; cfg++)
        for (int per = 1; per <= 3; per += 2)
          for (int inj = 0; inj < 2; inj++) begin
            measure(cp[0], cfg != 0, cfg == 2, per, inj[0], 1'b1);
            @(negedge clk_i);
            cyc++;
            chk(!ready_o, "R4 ready one cycle", ready_o, 0);
          end

    // R10: write in the ready cycle starts a new full burst
    measure(1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b1);
    measure(1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b1);
    @(negedge clk_i);
    chk(!ready_o && !low_en_o && !high_en_o, "R10 idle after chained burst",
        {low_en_o, high_en_o, ready_o}, 0);

    // R8: host-timed mode
    burst_n_i = 1'b1;
    @(negedge clk_i);
    for (int cfg = 0; cfg < 3; cfg++)
      for (int on = 0; on < 2; on++) begin
        single_i = (cfg != 0); col_i = (cfg == 2); tone_on_i = on[0];
        #1;
        chk(low_en_o == (on[0] && cfg != 2) && high_en_o == (on[0] && cfg != 1),
            "R8 host-timed enables", {low_en_o, high_en_o},
            {(on[0] && cfg != 2), (on[0] && cfg != 1)});
      end
    begin
      int rcount = 0, tcount = 0;
      tone_on_i = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        if (ready_o) rcount++;
        if (low_en_o || high_en_o) tcount++;
        wr_i = (i % 7 == 0);
        tick_i = 1'b1;
      end
      wr_i = 1'b0; tick_i = 1'b0;
      chk(rcount == 0, "R8 no ready in host-timed mode", rcount, 0);
      chk(tcount == 0, "R8 writes start no tone", tcount, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule